// File: doc/BRIEF.md
# Operate-Instruction Execute Unit

This block carries out the arithmetic and logic class of a small 16-bit load/store instruction set. Each cycle it may accept one 16-bit instruction word together with a valid strobe. It decodes the word and reads up to two operands from an internal bank of eight 16-bit registers. It computes an addition, a bitwise AND or a bitwise complement. On the next clock edge it writes the result back and records whether the result was negative, zero or positive.

A pipeline front end drives the unit. That front end sends only operate instructions, or it relies on the unit to drop the rest: any other opcode passes through with no effect. A write-back pulse marks every instruction that was executed. A combinational debug port lets a bench or a debugger look at any register at any time. Memory access, program-counter handling and interrupts are not part of this block.

Top module: `opx_unit`

## Requirements
- R1: After a cycle with rst_n low, all eight registers read 0, the flags read N=0 Z=1 P=0, and wb_vld_o is 0.
- R2: With opcode 0001 in bits 15:12 and bit 5 clear, the register named by bits 11:9 receives the sum of the registers named by bits 8:6 and 2:0. Bits 4:3 do not affect the result.
- R3: With bit 5 set, the ADD (0001) and AND (0101) forms take bits 4:0 as a two's complement immediate. Bit 4 is extended through bits 15:5, and the result is the second operand.
- R4: With opcode 0101, the destination receives the bitwise AND of the first source and the second operand, in either operand mode.
- R5: With opcode 1001, the destination (bits 11:9) receives the bitwise complement of the register named by bits 8:6. Bits 5:0 are not consulted.
- R6: Addition wraps modulo 2^16 with no other indication: 0x7FFF+1 gives 0x8000 and 0xFFFF+1 gives 0x0000.
- R7: After every executed instruction, exactly one flag is set. N is set when bit 15 of the result is 1, Z when the result is 0, and P otherwise.
- R8: An instruction with any other opcode, or any word presented while instr_vld_i is low, leaves every register and every flag unchanged and raises no write-back pulse.
- R9: When a source register is also the destination, the source reads the value held before the edge on which the write occurs. For example, ADD R3,R3,R3 doubles R3.
- R10: wb_vld_o is high for exactly the one cycle after each clock edge on which an instruction was executed, and is low otherwise.
- R11: dbg_data_o shows, without a clock, the current contents of the register selected by dbg_sel_i. After an edge it reflects any write made on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 16 | Instruction word |
| instr_vld_i | input | 1 | Instruction word is valid this cycle |
| dbg_sel_i | input | 3 | Register index for the debug read |
| dbg_data_o | output | 16 | Contents of the selected register |
| flag_n_o | output | 1 | Last result was negative |
| flag_z_o | output | 1 | Last result was zero |
| flag_p_o | output | 1 | Last result was positive |
| wb_vld_o | output | 1 | An instruction was written back on the last edge |

## Verification
The hardest conditions to reach from the ports are the wrap boundaries. Those need register values such as 0x8000 and 0x7FFF, and the 5-bit immediate cannot load them directly. The stimulus builds them in sequence: it clears a register and loads 1. It then doubles that register fifteen times with an instruction whose sources and destination are all the same register. Finally it complements the result. This sequence also exercises the read-before-write case on every step. After the directed sequence, random words drawn from all sixteen opcodes are applied with random strobes. A behavioural model is compared on every clock against all eight registers, the flags and the pulse.

// File: rtl/opx_pkg.sv
// Shared definitions for the operate execute unit.
// Assumes the fixed 16-bit instruction layout with a 4-bit opcode in bits 15:12.
package opx_pkg;
    localparam int INSTR_W = 16;
    localparam int SEL_W   = 3;

    localparam logic [3:0] OPC_ADD = 4'b0001;
    localparam logic [3:0] OPC_AND = 4'b0101;
    localparam logic [3:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_AND = 2'd1,
        ALU_NOT = 2'd2
    } alu_op_e;
endpackage

// File: rtl/opx_decode.sv
// Instruction decoder: splits an instruction word into register selects,
// the operation, the operand mode and a sign-extended immediate.
// Assumes the word is meaningful only while vld_i is high.
module opx_decode
    import opx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 5
) (
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               vld_i,
    output logic               we_o,
    output alu_op_e            op_o,
    output logic [SEL_W-1:0]   dst_o,
    output logic [SEL_W-1:0]   sa_o,
    output logic [SEL_W-1:0]   sb_o,
    output logic               use_imm_o,
    output logic [DATA_W-1:0]  imm_o
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [3:0] opc;
    logic       unused_fmt_bits;

    assign opc             = instr_i[15:12];
    assign dst_o           = instr_i[11:9];
    assign sa_o            = instr_i[8:6];
    assign sb_o            = instr_i[2:0];
    assign imm_o           = {{EXT_W{instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};
    assign unused_fmt_bits = ^instr_i[4:3];

    // Map the opcode to an operation and a write enable.
    always_comb begin
        we_o      = 1'b0;
        op_o      = ALU_ADD;
        use_imm_o = 1'b0;
        unique case (opc)
            OPC_ADD: begin we_o = vld_i; op_o = ALU_ADD; use_imm_o = instr_i[5]; end
            OPC_AND: begin we_o = vld_i; op_o = ALU_AND; use_imm_o = instr_i[5]; end
            OPC_NOT: begin we_o = vld_i; op_o = ALU_NOT; end
            default: begin we_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/opx_regfile.sv
// Register bank: REG_CNT words with two combinational operand reads,
// one combinational debug read and one clocked write port.
// Assumes reads see the value held before the write edge.
module opx_regfile #(
    parameter int DATA_W  = 16,
    parameter int REG_CNT = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [$clog2(REG_CNT)-1:0] wsel_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic [$clog2(REG_CNT)-1:0] rsel_a_i,
    input  logic [$clog2(REG_CNT)-1:0] rsel_b_i,
    input  logic [$clog2(REG_CNT)-1:0] rsel_d_i,
    output logic [DATA_W-1:0]          rdata_a_o,
    output logic [DATA_W-1:0]          rdata_b_o,
    output logic [DATA_W-1:0]          rdata_d_o
);
    logic [REG_CNT-1:0][DATA_W-1:0] regs;

    for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
        // Clear on reset, load when this entry is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we_i && (wsel_i == g))
                regs[g] <= wdata_i;
        end
    end

    assign rdata_a_o = regs[rsel_a_i];
    assign rdata_b_o = regs[rsel_b_i];
    assign rdata_d_o = regs[rsel_d_i];

    // R8: without a write enable no entry changes.
    a_r8_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(regs));
endmodule

// File: rtl/opx_alu.sv
// Combinational operate datapath: wrapping add, bitwise AND, complement.
// Assumes the second operand has already been muxed by the caller.
module opx_alu
    import opx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] res_o
);
    // Select the result of the requested operation.
    always_comb begin
        unique case (op_i)
            ALU_ADD: res_o = a_i + b_i;
            ALU_AND: res_o = a_i & b_i;
            ALU_NOT: res_o = ~a_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/opx_flags.sv
// Condition code register: holds a one-hot negative/zero/positive code
// that follows every written result. Resets to zero.
module opx_flags #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [DATA_W-1:0] res_i,
    output logic [2:0]        nzp_o
);
    logic [2:0] nzp_next;

    // Classify the incoming result.
    always_comb begin
        if (res_i[DATA_W-1])  nzp_next = 3'b100;
        else if (res_i == '0) nzp_next = 3'b010;
        else                  nzp_next = 3'b001;
    end

    // Hold the code, replacing it on each write-back.
    always_ff @(posedge clk) begin
        if (!rst_n)     nzp_o <= 3'b010;
        else if (upd_i) nzp_o <= nzp_next;
    end

    // R7: exactly one flag at all times after reset.
    a_r7_flags_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(nzp_o) == 1);
    // R7: a zero result leaves only Z set.
    a_r7_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && res_i == '0) |=> nzp_o == 3'b010);
    // R8: no update, no flag change.
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> $stable(nzp_o));
endmodule

// File: rtl/opx_unit.sv
// Operate execute unit top: decode, register read, compute, write back
// and flag update in one clock; write-back pulse one cycle later.
// Assumes one instruction per cycle at most, no stalls.
module opx_unit
    import opx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int IMM_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               instr_vld_i,
    input  logic [SEL_W-1:0]   dbg_sel_i,
    output logic [DATA_W-1:0]  dbg_data_o,
    output logic               flag_n_o,
    output logic               flag_z_o,
    output logic               flag_p_o,
    output logic               wb_vld_o
);
    localparam int REG_CNT = 1 << SEL_W;

    logic              we;
    alu_op_e           op;
    logic [SEL_W-1:0]  dst, sa, sb;
    logic              use_imm;
    logic [DATA_W-1:0] imm, ra, rb, opb, res;
    logic [2:0]        nzp;

    opx_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dec (
        .instr_i(instr_i), .vld_i(instr_vld_i), .we_o(we), .op_o(op),
        .dst_o(dst), .sa_o(sa), .sb_o(sb), .use_imm_o(use_imm), .imm_o(imm)
    );

    opx_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
        .clk(clk), .rst_n(rst_n), .we_i(we), .wsel_i(dst), .wdata_i(res),
        .rsel_a_i(sa), .rsel_b_i(sb), .rsel_d_i(dbg_sel_i),
        .rdata_a_o(ra), .rdata_b_o(rb), .rdata_d_o(dbg_data_o)
    );

    assign opb = use_imm ? imm : rb;

    opx_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i(op), .a_i(ra), .b_i(opb), .res_o(res)
    );

    opx_flags #(.DATA_W(DATA_W)) u_flg (
        .clk(clk), .rst_n(rst_n), .upd_i(we), .res_i(res), .nzp_o(nzp)
    );

    assign flag_n_o = nzp[2];
    assign flag_z_o = nzp[1];
    assign flag_p_o = nzp[0];

    // Register the write-back pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) wb_vld_o <= 1'b0;
        else        wb_vld_o <= we;
    end

    // R10: an accepted operate instruction is followed by a pulse.
    a_r10_wb_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_vld_i && (instr_i[15:12] == OPC_ADD || instr_i[15:12] == OPC_AND ||
                         instr_i[15:12] == OPC_NOT)) |=> wb_vld_o);
    // R8: an invalid strobe is followed by no pulse.
    a_r8_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_vld_i |=> !wb_vld_o);
endmodule

// File: tb/opx_unit_bench.sv
`timescale 1ns/100ps
module opx_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = '0;
    logic        vld = 1'b0;
    logic [2:0]  dsel = '0;
    logic [15:0] ddata;
    logic        fn, fz, fp, wbv;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference state.
    logic [15:0] m_reg [8];
    logic [2:0]  m_nzp;
    logic        m_wb;

    opx_unit u_opx_unit (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .instr_vld_i(vld),
        .dbg_sel_i(dsel), .dbg_data_o(ddata), .flag_n_o(fn), .flag_z_o(fz),
        .flag_p_o(fp), .wb_vld_o(wbv)
    );

    always #5 clk = ~clk;

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rr(logic [3:0] op, int d, int a, int b);
        return {op, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction
    function automatic logic [15:0] ri(logic [3:0] op, int d, int a, int imm);
        return {op, 3'(d), 3'(a), 1'b1, 5'(imm)};
    endfunction
    function automatic logic [15:0] nt(int d, int a, logic [5:0] junk);
        return {4'b1001, 3'(d), 3'(a), junk};
    endfunction

    // Apply the word to the model.
    task automatic model(logic [15:0] w, logic v);
        logic [15:0] a, b, r;
        logic [3:0]  op;
        op = w[15:12];
        a  = m_reg[w[8:6]];
        b  = w[5] ? {{11{w[4]}}, w[4:0]} : m_reg[w[2:0]];
        m_wb = 1'b0;
        if (v && (op == 4'b0001 || op == 4'b0101 || op == 4'b1001)) begin
            if (op == 4'b0001)      r = 16'((int'(a) + int'(b)) % 65536);
            else if (op == 4'b0101) r = a & b;
            else                    r = ~a;
            m_reg[w[11:9]] = r;
            m_nzp = r[15] ? 3'b100 : (r == 0 ? 3'b010 : 3'b001);
            m_wb = 1'b1;
        end
    endtask

    task automatic compare(string tag);
        check({"R7 flags ", tag}, {13'd0, fn, fz, fp}, {13'd0, m_nzp});
        check({"R10 wb ", tag}, {15'd0, wbv}, {15'd0, m_wb});
        for (int i = 0; i < 8; i++) begin
            dsel = 3'(i);
            #0.2;
            check({"R11 reg ", tag}, ddata, m_reg[i]);
        end
    endtask

    // One clock: drive at negedge, compare shortly after posedge.
    task automatic step(string tag, logic [15:0] w, logic v = 1'b1);
        @(negedge clk);
        instr = w;
        vld = v;
        @(posedge clk);
        model(w, v);
        #2;
        compare(tag);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_nzp = 3'b010;
        m_wb = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        compare("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        step("R3 add imm pos", ri(4'b0001, 1, 0, 5));
        step("R3 add imm neg", ri(4'b0001, 2, 0, -3));
        step("R2 add reg", rr(4'b0001, 3, 1, 2));
        step("R2 add reg junk bits 4:3", rr(4'b0001, 4, 1, 2) | 16'h0018);
        step("R4 and reg", rr(4'b0101, 5, 2, 1));
        step("R4 and imm", ri(4'b0101, 6, 2, 5'h0E));
        step("R5 not", nt(7, 2, 6'h15));
        step("R5 not zero", nt(7, 7, 6'h00));
        step("R4 clear", ri(4'b0101, 3, 3, 0));
        step("R3 load one", ri(4'b0001, 3, 3, 1));
        for (int i = 0; i < 15; i++) step("R9 double in place", rr(4'b0001, 3, 3, 3));
        step("R5 not 8000", nt(4, 3, 6'h3F));
        step("R6 7fff plus 1", ri(4'b0001, 5, 4, 1));
        step("R3 minus one", ri(4'b0101, 6, 6, 0));
        step("R3 ffff", ri(4'b0001, 6, 6, -1));
        step("R6 ffff plus 1", ri(4'b0001, 0, 6, 1));
        step("R8 opcode 0000", 16'h0E3F);
        step("R8 opcode 1111", 16'hFFFF);
        step("R8 vld low", ri(4'b0001, 1, 6, 3), 1'b0);
        step("R10 gap", 16'h2000);

        for (int k = 0; k < 400; k++) begin
            logic [15:0] w;
            logic v;
            w = 16'($urandom);
            if (k % 2 == 0) w[15:12] = (k % 3 == 0) ? 4'b0001 : ((k % 3 == 1) ? 4'b0101 : 4'b1001);
            v = ($urandom % 4) != 0;
            step("R8 random", w, v);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #200000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule